// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers characters from one start/stop framed serial line. It runs on a local clock at 1, 16 or 64 times the bit rate, and the ratio is chosen at run time. The line rests high. A high-to-low transition marks a start bit. In the oversampled modes the start bit is confirmed at its centre. Every later bit is then sampled at its own centre, and the data bits are collected least significant bit first.

The format input sets four things: the character length (7 or 8 bits), whether a parity bit follows, whether that parity is odd or even, and whether one or two stop bits end the frame. The receiver takes the ratio and the format when it detects the start edge, and uses those values for the whole character. A finished character goes into a holding register together with its parity and framing error flags. A data-ready flag tells the host a character is waiting. A one-cycle read strobe from the host consumes the character. If a second character completes before the first has been read, the overrun flag is set.

Top module: `async_char_rx`

## Requirements
- R1: While rst_ni is low, data_o is 0 and ready_o, parity_err_o, frame_err_o and overrun_o are all 0.
- R2: rx_i passes through a two-flop synchroniser. A character begins at a falling edge on the synchronised line. Data bits arrive least significant bit first, the start bit is 0 and the stop bits are 1. On the clock edge that takes the centre sample of the last stop bit, data_o loads the character and ready_o goes to 1. data_o changes only on such an edge.
- R3: ratio_sel_i selects 00 = 1x, 01 = 16x, 10 or 11 = 64x. Count the first low synchronised sample as index 0. With ratio N>1, bit k after the start bit is sampled at index N/2 + (k+1)·N.
- R4: In 16x and 64x modes the start bit is checked again at sample index N/2. If the line is high by then, the start is dropped without any effect on the outputs, and the receiver waits for the next falling edge.
- R5: In 1x mode there is no start check. The start bit is the sample at index 0, and each later bit is the next sample, one per clock.
- R6: fmt_i bit 0 = 8 data bits (else 7), bit 1 = parity enabled, bit 2 = odd parity (else even), bit 3 = two stop bits (else one). In 7-bit format, data_o[7] reads 0.
- R7: parity_err_o is 1 when the received data bits plus the parity bit have an odd count of ones under even parity, or an even count under odd parity. With parity disabled it is 0.
- R8: frame_err_o is 1 when any stop-bit sample was 0. parity_err_o and frame_err_o load together with data_o, and they keep their values, even across a read, until the next character completes.
- R9: If a character completes while ready_o is 1 and rd_i is 0 in that cycle, overrun_o becomes 1 on that edge. The new character replaces the old one, ready_o stays 1, and the next start edge is still recognised normally.
- R10: rd_i high clears ready_o and overrun_o on the next edge, unless a character completes on that same edge. In that case ready_o is 1 and overrun_o is 0.
- R11: ratio_sel_i and fmt_i are captured at the start edge. Changing them during a character has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sample clock (1/16/64 x bit rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| ratio_sel_i | input | 2 | Clock-to-bit-rate ratio select |
| fmt_i | input | 4 | Character format select |
| rd_i | input | 1 | Host read strobe, consumes the held character |
| data_o | output | 8 | Held character |
| ready_o | output | 1 | Held character not yet read |
| parity_err_o | output | 1 | Parity mismatch on held character |
| frame_err_o | output | 1 | Missing stop bit on held character |
| overrun_o | output | 1 | A character was lost before being read |

## Verification
The bench goes after off-by-one sample timing: a design that samples one count early or late still decodes a clean line, but the per-clock comparison shows when ready_o rises, so the error is caught. Short low pulses test glitch rejection; a receiver that skips the midpoint check would deliver a spurious character. Odd parity with a flipped parity bit, a 7-bit character with bit 7 set on the line, and a bad second stop bit catch designs that compute parity with the wrong sense, keep the eighth bit, or check only one stop bit. A second unread character and a format change in mid-frame catch an overrun flag that is missing or late, and settings that are sampled live instead of captured at the start edge.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS
  } rx_state_e;

  // bit 0 = len8, bit 3 = stop2
  typedef struct packed {
    logic stop2;
    logic par_odd;
    logic par_en;
    logic len8;
  } rx_fmt_t;

  localparam logic [1:0] RATIO_X1  = 2'b00;
  localparam logic [1:0] RATIO_X16 = 2'b01;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  // pipe[STAGES] keeps the previous synchronised value for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign q_o    = pipe_q[STAGES-1];
  assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RATIO_MID = 16,
  parameter int RATIO_HI  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              fall_i,
  input  logic [1:0]        ratio_sel_i,
  input  logic [3:0]        fmt_i,
  output logic              done_o,
  output logic [DATA_W-1:0] char_o,
  output logic              par_err_o,
  output logic              frame_err_o,
  output logic              len8_o,
  output logic              par_en_o
);
  localparam int CNT_W = $clog2(RATIO_HI);
  localparam int IDX_W = $clog2(DATA_W + 4);

  function automatic logic [CNT_W-1:0] last_of(input logic [1:0] sel);
    case (sel)
      RATIO_X1:  return '0;
      RATIO_X16: return CNT_W'(RATIO_MID - 1);
      default:   return CNT_W'(RATIO_HI - 1);
    endcase
  endfunction

  rx_state_e         state_q;
  rx_fmt_t           fmt_q;
  logic [1:0]        ratio_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              pbit_q;
  logic              fe_q;

  logic [CNT_W-1:0]  last_cnt, mid_cnt;
  logic [IDX_W-1:0]  data_len, last_idx;
  logic              tick, in_data, in_par, last_bit;

  assign last_cnt = last_of(ratio_q);
  assign mid_cnt  = last_cnt >> 1;
  assign tick     = (cnt_q == last_cnt);
  assign data_len = fmt_q.len8 ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign last_idx = data_len + IDX_W'(fmt_q.par_en) + IDX_W'(fmt_q.stop2);
  assign in_data  = (idx_q < data_len);
  assign in_par   = fmt_q.par_en && (idx_q == data_len);
  assign last_bit = (idx_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fmt_q   <= '0;
      ratio_q <= RATIO_X16;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      pbit_q  <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fall_i) begin
            fmt_q   <= rx_fmt_t'(fmt_i);
            ratio_q <= ratio_sel_i;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            pbit_q  <= 1'b0;
            fe_q    <= 1'b0;
            state_q <= (last_of(ratio_sel_i) == '0) ? ST_BITS : ST_START;
          end
        end
        ST_START: begin
          if (cnt_q == mid_cnt) begin
            cnt_q   <= '0;
            state_q <= rx_i ? ST_IDLE : ST_BITS;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_BITS: begin
          if (tick) begin
            cnt_q <= '0;
            if (in_data) begin
              for (int i = 0; i < DATA_W; i++)
                if (idx_q == IDX_W'(i)) shift_q[i] <= rx_i;
            end else if (in_par) begin
              pbit_q <= rx_i;
            end else if (!rx_i) begin
              fe_q <= 1'b1;
            end
            if (last_bit) state_q <= ST_IDLE;
            else          idx_q   <= idx_q + IDX_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // last bit is always a stop bit; its sample is rx_i in the done cycle
  assign done_o      = (state_q == ST_BITS) && tick && last_bit;
  assign char_o      = shift_q;
  assign par_err_o   = fmt_q.par_en & (^{shift_q, pbit_q} ^ fmt_q.par_odd);
  assign frame_err_o = fe_q | ~rx_i;
  assign len8_o      = fmt_q.len8;
  assign par_en_o    = fmt_q.par_en;
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      pe_o    <= 1'b0;
      fe_o    <= 1'b0;
      ovr_o   <= 1'b0;
    end else if (done_i) begin
      data_o  <= char_i;
      pe_o    <= pe_i;
      fe_o    <= fe_i;
      ready_o <= 1'b1;
      ovr_o   <= ~rd_i & (ovr_o | ready_o);
    end else if (rd_i) begin
      ready_o <= 1'b0;
      ovr_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx #(
  parameter int DATA_W    = 8,
  parameter int RATIO_MID = 16,
  parameter int RATIO_HI  = 64,
  parameter int SYNC_FF   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [1:0]        ratio_sel_i,
  input  logic [3:0]        fmt_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              rx_s, rx_fall;
  logic              char_done, char_pe, char_fe, frm_len8, frm_par_en;
  logic [DATA_W-1:0] char_val;

  async_rx_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s),
    .fall_o (rx_fall)
  );

  async_rx_frame #(
    .DATA_W    (DATA_W),
    .RATIO_MID (RATIO_MID),
    .RATIO_HI  (RATIO_HI)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_i        (rx_s),
    .fall_i      (rx_fall),
    .ratio_sel_i (ratio_sel_i),
    .fmt_i       (fmt_i),
    .done_o      (char_done),
    .char_o      (char_val),
    .par_err_o   (char_pe),
    .frame_err_o (char_fe),
    .len8_o      (frm_len8),
    .par_en_o    (frm_par_en)
  );

  async_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (char_done),
    .char_i  (char_val),
    .pe_i    (char_pe),
    .fe_i    (char_fe),
    .rd_i    (rd_i),
    .data_o  (data_o),
    .ready_o (ready_o),
    .pe_o    (parity_err_o),
    .fe_o    (frame_err_o),
    .ovr_o   (overrun_o)
  );
endmodule

// File: rtl/async_char_rx_chk.sv
module async_char_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              done_i,
  input logic              len8_i,
  input logic              par_en_i,
  input logic [DATA_W-1:0] data_i,
  input logic              ready_i,
  input logic              pe_i,
  input logic              ovr_i
);
  // R2
  ready_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_i);

  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_i));

  // R6
  len7_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !len8_i |=> !data_i[DATA_W-1]);

  // R7
  no_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !par_en_i |=> !pe_i);

  // R9
  ovr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> $past(done_i));

  // R9
  ovr_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |-> ready_i);

  // R10
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !ready_i && !ovr_i);
endmodule

bind async_char_rx async_char_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .done_i   (char_done),
  .len8_i   (frm_len8),
  .par_en_i (frm_par_en),
  .data_i   (data_o),
  .ready_i  (ready_o),
  .pe_i     (parity_err_o),
  .ovr_i    (overrun_o)
);

// File: tb/async_char_rx_bench.sv
module async_char_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       rd = 1'b0;
  logic [1:0] ratio = 2'b01;
  logic [3:0] fmt = 4'b0001;
  logic [7:0] data;
  logic       rdy, pe, fe, ovr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  async_char_rx u_async_char_rx (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_i         (rx),
    .ratio_sel_i  (ratio),
    .fmt_i        (fmt),
    .rd_i         (rd),
    .data_o       (data),
    .ready_o      (rdy),
    .parity_err_o (pe),
    .frame_err_o  (fe),
    .overrun_o    (ovr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio_n(input logic [1:0] s);
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 16;
    return 64;
  endfunction

  // behavioural reference model
  int   m_s1 = 1, m_s2 = 1, m_prev = 1;
  int   m_st = 0, m_cnt = 0, m_idx = 0, m_n = 16, m_len = 8;
  int   m_par = 0, m_odd = 0, m_two = 0, m_pbit = 0, m_fe = 0;
  bit   m_done;
  logic [7:0] m_chr = 8'h00;
  logic [7:0] e_data = 8'h00;
  logic e_rdy = 0, e_pe = 0, e_fe = 0, e_ovr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_st = 0; m_cnt = 0; m_idx = 0;
      m_chr = 0; e_data = 0; e_rdy = 0; e_pe = 0; e_fe = 0; e_ovr = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (m_s2 == 0 && m_prev == 1) begin
             m_n = ratio_n(ratio); m_len = fmt[0] ? 8 : 7;
             m_par = fmt[1]; m_odd = fmt[2]; m_two = fmt[3];
             m_cnt = 0; m_idx = 0; m_chr = 0; m_fe = 0; m_pbit = 0;
             m_st = (m_n == 1) ? 2 : 1;
           end
        1: if (m_cnt == m_n / 2 - 1) begin
             m_cnt = 0;
             m_st = (m_s2 == 1) ? 0 : 2;
           end else m_cnt++;
        default: if (m_cnt == m_n - 1) begin
             m_cnt = 0;
             if (m_idx < m_len) m_chr[m_idx] = m_s2[0];
             else if (m_par == 1 && m_idx == m_len) m_pbit = m_s2;
             else if (m_s2 == 0) m_fe = 1;
             if (m_idx == m_len + m_par + m_two) begin m_done = 1; m_st = 0; end
             else m_idx++;
           end else m_cnt++;
      endcase
      if (m_done) begin
        e_ovr  = !rd && (e_ovr || e_rdy);
        e_rdy  = 1;
        e_data = m_chr;
        e_fe   = m_fe[0];
        e_pe   = (m_par == 1) && ((($countones(m_chr) + m_pbit) % 2) != m_odd);
      end else if (rd) begin
        e_rdy = 0;
        e_ovr = 0;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(rx);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 data", data, e_data);
      check("R2 ready", {7'd0, rdy}, {7'd0, e_rdy});
      check("R7 parity", {7'd0, pe}, {7'd0, e_pe});
      check("R8 framing", {7'd0, fe}, {7'd0, e_fe});
      check("R9 overrun", {7'd0, ovr}, {7'd0, e_ovr});
    end
  end

  task automatic drive(input int n, input logic v);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int c);
    drive(c, 1'b1);
  endtask

  task automatic tx_frame(input int n, input logic [7:0] d, input int len, input bit par,
                          input bit odd, input bit two, input bit flip, input bit bad_stop);
    logic pb;
    pb = ^(d & ((len == 8) ? 8'hFF : 8'h7F)) ^ odd;
    if (flip) pb = ~pb;
    drive(n, 1'b0);
    for (int i = 0; i < len; i++) drive(n, d[i]);
    if (par) drive(n, pb);
    if (two) drive(n, 1'b1);
    drive(n, !bad_stop);
  endtask

  task automatic host_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 data", data, 8'h00);
    check("R1 flags", {3'd0, rdy, pe, fe, ovr, 1'b0}, 8'h00);
    rst_n = 1'b1;
    idle(10);

    // 16x 8N1
    ratio = 2'b01; fmt = 4'b0001; idle(4);
    tx_frame(16, 8'hA5, 8, 0, 0, 0, 0, 0); idle(8);
    check("R2 char", data, 8'hA5);
    check("R2 ready", {7'd0, rdy}, 8'd1);
    host_read(); idle(2);
    check("R10 read clears ready", {7'd0, rdy}, 8'd0);

    // 64x 8E1 good parity
    ratio = 2'b10; fmt = 4'b0011; idle(4);
    tx_frame(64, 8'h3C, 8, 1, 0, 0, 0, 0); idle(8);
    check("R3 64x char", data, 8'h3C);
    check("R7 good even parity", {7'd0, pe}, 8'd0);
    host_read();

    // 64x 8O1 flipped parity
    fmt = 4'b0111; idle(4);
    tx_frame(64, 8'h5A, 8, 1, 1, 0, 1, 0); idle(8);
    check("R7 odd parity error", {7'd0, pe}, 8'd1);
    host_read(); idle(2);
    check("R8 error held after read", {7'd0, pe}, 8'd1);

    // 16x 7E2, bad second stop
    ratio = 2'b01; fmt = 4'b1010; idle(4);
    tx_frame(16, 8'hD3, 7, 1, 0, 1, 0, 1); idle(20);
    check("R6 7-bit char", data, 8'h53);
    check("R8 framing error", {7'd0, fe}, 8'd1);
    host_read();

    // 1x 8N1
    ratio = 2'b00; fmt = 4'b0001; idle(6);
    tx_frame(1, 8'h81, 8, 0, 0, 0, 0, 0); idle(8);
    check("R5 1x char", data, 8'h81);
    check("R8 framing clear", {7'd0, fe}, 8'd0);
    host_read();

    // glitch then real character at 16x
    ratio = 2'b01; idle(6);
    drive(4, 1'b0); idle(30);
    check("R4 glitch ignored", {7'd0, rdy}, 8'd0);
    tx_frame(16, 8'h12, 8, 0, 0, 0, 0, 0); idle(8);
    check("R4 char after glitch", data, 8'h12);

    // overrun
    host_read(); idle(4);
    tx_frame(16, 8'h11, 8, 0, 0, 0, 0, 0); idle(8);
    tx_frame(16, 8'h22, 8, 0, 0, 0, 0, 0); idle(8);
    check("R9 overrun set", {7'd0, ovr}, 8'd1);
    check("R9 new char kept", data, 8'h22);
    check("R9 ready kept", {7'd0, rdy}, 8'd1);
    host_read(); idle(2);
    check("R10 read clears overrun", {6'd0, rdy, ovr}, 8'd0);

    // read before second character completes
    tx_frame(16, 8'h44, 8, 0, 0, 0, 0, 0); idle(4);
    fork
      tx_frame(16, 8'h55, 8, 0, 0, 0, 0, 0);
      begin @(negedge clk); host_read(); end
    join
    idle(8);
    check("R10 no overrun after read", {7'd0, ovr}, 8'd0);
    check("R10 char", data, 8'h55);
    host_read();

    // format change mid-character
    fmt = 4'b0001; idle(4);
    fork
      tx_frame(16, 8'hC6, 8, 0, 0, 0, 0, 0);
      begin repeat (40) @(negedge clk); fmt = 4'b0110; ratio = 2'b10; end
    join
    idle(8);
    check("R11 format latched", data, 8'hC6);
    check("R11 no parity", {7'd0, pe}, 8'd0);
    fmt = 4'b0001; ratio = 2'b01;
    host_read(); idle(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule